// File: doc/BRIEF.md
# Reverse-Order Guarded Strobe Sequencer

This block drives one shift step of a register that is split into K segments built from level-sensitive storage. A single request must not become one shared enable, since every stage would then see its input change while it is open. The sequencer instead produces K+1 separate one-cycle strobes that never overlap. The first is a transfer strobe that moves each segment's last bit into a holding stage. The data strobes then follow from the last position (K) down to the first (1), so each stage captures a value that is no longer moving.

A run-time gap setting inserts 0 to 7 idle cycles after every strobe. The value is captured when a request is accepted. While a sequence runs, `shift_ready` is low and `busy` is high, and further requests are not taken. One cycle after strobe 1, a one-cycle `seq_done` pulse marks the end of the step. `shift_ready` returns high in that same cycle, so a request held high from then on is accepted at the next clock edge.

Top module: `strobe_seq`

## Requirements
- R1: A request (`shift_req` high at a rising edge while `shift_ready` is high) makes `strobe_t` high for exactly the one cycle after that edge.
- R2: After `strobe_t`, the data strobes fire once each in descending order K, K-1, ..., 1, each for one cycle. Bit i of `strobe_d` is strobe i+1. One request gives exactly K+1 strobes.
- R3: With G the value of `gap_cfg` at the accepting edge, exactly G all-low cycles separate consecutive strobes. Strobe number m (0 for `strobe_t`) is therefore high m*(G+1) cycles after `strobe_t`.
- R4: At no time is more than one of the K+1 strobe outputs high, including when G is 0.
- R5: `busy` is the inverse of `shift_ready`. `busy` is high from the cycle after acceptance through the cycle of strobe 1. A `shift_req` while busy is ignored and adds no strobe.
- R6: `seq_done` is high for exactly one cycle, the cycle after strobe 1, and `shift_ready` is high in that cycle.
- R7: A request held high is accepted again in the `seq_done` cycle. Consecutive `strobe_t` pulses are then K*(G+1)+2 cycles apart: one cycle of trigger latency, K strobe spacings, and one cycle of capture latency.
- R8: Changes on `gap_cfg` after acceptance do not alter the running sequence.
- R9: A synchronous active-high `rst` gives, from the next cycle on, all strobes low, `seq_done` low, `busy` low and `shift_ready` high. This holds even when reset interrupts a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_req | input | 1 | Request one shift step |
| gap_cfg | input | GAP_W | Idle cycles between strobes, sampled on acceptance |
| shift_ready | output | 1 | High when a request can be accepted |
| busy | output | 1 | High while a sequence runs |
| strobe_t | output | 1 | Transfer strobe, first in every sequence |
| strobe_d | output | NUM_SEG | Data strobes; bit i is strobe i+1 |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The main function is swept over every gap value from 0 to 7 with K=4. In every cycle the full strobe vector is compared against the arithmetic slot position m*(G+1), so both a wrong order and a wrong spacing show up. During each sequence the request is held high and the gap input is driven with a different value. This separates a design that ignores both from one that restarts or re-reads the gap. Chained requests across three different gaps check the minimum period and the acceptance in the done cycle. A reset in the middle of a sequence, with the request held high, checks that the sequencer returns to idle and does not resume.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_FIRE = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/strobe_seq_ctrl.sv
module strobe_seq_ctrl
  import strobe_seq_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int GAP_W   = 3,
  localparam int SLOT_W = $clog2(NUM_SEG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [GAP_W-1:0]  gap_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fire_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SEG);

  seq_state_e        st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [GAP_W-1:0]  gcnt_q, gcnt_d;
  logic              ready_q, ready_d;
  logic              busy_q;
  logic              done_q, done_d;
  logic              fire;

  // The slot that will be visible next cycle is decided here.
  // The strobe bank registers it.
  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    gap_d   = gap_q;
    gcnt_d  = gcnt_q;
    ready_d = ready_q;
    done_d  = 1'b0;
    fire    = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (req_i) begin
          gap_d   = gap_i;
          slot_d  = '0;
          fire    = 1'b1;
          ready_d = 1'b0;
          st_d    = SEQ_FIRE;
        end
      end
      SEQ_FIRE: begin
        if (slot_q == LAST_SLOT) begin
          st_d    = SEQ_IDLE;
          done_d  = 1'b1;
          ready_d = 1'b1;
        end else if (gap_q == '0) begin
          slot_d = slot_q + SLOT_W'(1);
          fire   = 1'b1;
        end else begin
          st_d   = SEQ_GAP;
          gcnt_d = gap_q - GAP_W'(1);
        end
      end
      SEQ_GAP: begin
        if (gcnt_q == '0) begin
          st_d   = SEQ_FIRE;
          slot_d = slot_q + SLOT_W'(1);
          fire   = 1'b1;
        end else begin
          gcnt_d = gcnt_q - GAP_W'(1);
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SEQ_IDLE;
      slot_q  <= '0;
      gap_q   <= '0;
      gcnt_q  <= '0;
      ready_q <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      gap_q   <= gap_d;
      gcnt_q  <= gcnt_d;
      ready_q <= ready_d;
      busy_q  <= ~ready_d;
      done_q  <= done_d;
    end
  end

  assign ready_o = ready_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign fire_o  = fire & ~rst;
  assign slot_o  = slot_d;

endmodule

// File: rtl/strobe_seq_bank.sv
module strobe_seq_bank #(
  parameter int NUM_SEG = 4,
  localparam int SLOT_W = $clog2(NUM_SEG + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire_i,
  input  logic [SLOT_W-1:0]  slot_i,
  output logic               strobe_t_o,
  output logic [NUM_SEG-1:0] strobe_d_o
);

  // Each output register is the AND of the launch qualifier and its own slot match.
  // Slot 0 is the transfer strobe. Slot m (m >= 1) is data strobe NUM_SEG+1-m.
  for (genvar g = 0; g <= NUM_SEG; g++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk) begin
      if (rst) lane_q <= 1'b0;
      else     lane_q <= fire_i & (slot_i == SLOT_W'(g));
    end
    if (g == 0) begin : g_xfer
      assign strobe_t_o = lane_q;
    end else begin : g_data
      assign strobe_d_o[NUM_SEG-g] = lane_q;
    end
  end

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq #(
  parameter int NUM_SEG = 4,
  parameter int GAP_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_req,
  input  logic [GAP_W-1:0]   gap_cfg,
  output logic               shift_ready,
  output logic               busy,
  output logic               strobe_t,
  output logic [NUM_SEG-1:0] strobe_d,
  output logic               seq_done
);

  localparam int SLOT_W = $clog2(NUM_SEG + 1);

  logic              fire;
  logic [SLOT_W-1:0] slot;

  strobe_seq_ctrl #(.NUM_SEG(NUM_SEG), .GAP_W(GAP_W)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .req_i   (shift_req),
    .gap_i   (gap_cfg),
    .ready_o (shift_ready),
    .busy_o  (busy),
    .done_o  (seq_done),
    .fire_o  (fire),
    .slot_o  (slot)
  );

  strobe_seq_bank #(.NUM_SEG(NUM_SEG)) bank_i (
    .clk        (clk),
    .rst        (rst),
    .fire_i     (fire),
    .slot_i     (slot),
    .strobe_t_o (strobe_t),
    .strobe_d_o (strobe_d)
  );

endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk #(
  parameter int NUM_SEG = 4,
  parameter int GAP_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               shift_req,
  input logic [GAP_W-1:0]   gap_cfg,
  input logic               shift_ready,
  input logic               busy,
  input logic               strobe_t,
  input logic [NUM_SEG-1:0] strobe_d,
  input logic               seq_done
);

  AST_ACCEPT_GIVES_T: assert property (@(posedge clk) disable iff (rst)
    (shift_req && shift_ready) |=> strobe_t); // R1
  AST_T_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    strobe_t |=> !strobe_t); // R1
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe_t, strobe_d})); // R4
  AST_READY_INVERSE: assert property (@(posedge clk) disable iff (rst)
    shift_ready != busy); // R5
  AST_STROBES_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (strobe_t || (strobe_d != '0)) |-> busy); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    strobe_d[0] |=> (seq_done && shift_ready)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (shift_ready && !busy && !strobe_t && strobe_d == '0 && !seq_done)); // R9

endmodule

bind strobe_seq strobe_seq_chk #(.NUM_SEG(NUM_SEG), .GAP_W(GAP_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .shift_req   (shift_req),
  .gap_cfg     (gap_cfg),
  .shift_ready (shift_ready),
  .busy        (busy),
  .strobe_t    (strobe_t),
  .strobe_d    (strobe_d),
  .seq_done    (seq_done)
);

// File: tb/strobe_seq_tb_top.sv
`timescale 1ns/1ps
module strobe_seq_tb_top;

  localparam int K  = 4;
  localparam int GW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shift_req = 1'b0;
  logic [GW-1:0] gap_cfg = '0;
  logic          shift_ready, busy, strobe_t, seq_done;
  logic [K-1:0]  strobe_d;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  strobe_seq #(.NUM_SEG(K), .GAP_W(GW)) dut_i (
    .clk(clk), .rst(rst), .shift_req(shift_req), .gap_cfg(gap_cfg),
    .shift_ready(shift_ready), .busy(busy), .strobe_t(strobe_t),
    .strobe_d(strobe_d), .seq_done(seq_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int strobes();
    return int'({strobe_t, strobe_d});
  endfunction

  // Idle state: no strobes, ready, not busy, no done (R9 / R5).
  task automatic chk_idle(input string tag);
    chk({tag, " strobes"}, strobes(), 0);
    chk({tag, " ready"}, int'(shift_ready), 1);
    chk({tag, " busy"}, int'(busy), 0);
    chk({tag, " done"}, int'(seq_done), 0);
  endtask

  // The caller has already driven shift_req=1 and gap_cfg=g at a negedge while ready.
  // Cycle c=0 is the strobe_t cycle (R1). Slot m is high at c=m*(g+1) (R2, R3).
  // Done is at c=K*(g+1)+1 (R6).
  task automatic run_seq(input int g, input int gn, input bit chain);
    int last;
    last = K * (g + 1) + 1;
    for (int c = 0; c <= last; c++) begin
      int e;
      @(posedge clk);
      @(negedge clk);
      e = 0;
      if (c < last && (c % (g + 1)) == 0) e = 1 << (K - c / (g + 1));
      chk($sformatf("R2 R3 R4 strobes g=%0d c=%0d", g, c), strobes(), e);
      chk($sformatf("R6 done g=%0d c=%0d", g, c), int'(seq_done), int'(c == last));
      chk($sformatf("R5 ready g=%0d c=%0d", g, c), int'(shift_ready), int'(c == last));
      chk($sformatf("R5 busy g=%0d c=%0d", g, c), int'(busy), int'(c != last));
      if (c == last) begin
        shift_req = chain;
        gap_cfg   = GW'(gn);
      end else begin
        shift_req = 1'b1;             // R5: ignored while busy
        gap_cfg   = GW'(7 - g);       // R8: must not change the spacing
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    shift_req = 1'b1;              // held high during reset: must not start (R9)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R9 reset");
    rst = 1'b0;
    shift_req = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_idle("R9 after reset");

    // Sweep every gap value (R1-R6, R8).
    for (int g = 0; g < 8; g++) begin
      shift_req = 1'b1;
      gap_cfg   = GW'(g);
      run_seq(g, 0, 1'b0);
      @(posedge clk); @(negedge clk);
      chk_idle($sformatf("R5 idle after g=%0d", g));
    end

    // Back-to-back requests: minimum period K*(G+1)+2 (R7).
    shift_req = 1'b1;
    gap_cfg   = GW'(0);
    run_seq(0, 3, 1'b1);
    run_seq(3, 7, 1'b1);
    run_seq(7, 1, 1'b0);
    @(posedge clk); @(negedge clk);
    chk_idle("R7 idle after chain");

    // Reset in the middle of a sequence (R9).
    shift_req = 1'b1;
    gap_cfg   = GW'(2);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R9 mid-sequence busy", int'(busy), 1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_idle("R9 mid reset");
    shift_req = 1'b0;
    rst = 1'b0;
    repeat (12) begin
      @(posedge clk); @(negedge clk);
      chk_idle("R9 no resume");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule